// File: doc/BRIEF.md
# CAN Controller Mode Control Registers

This block is the small register island that decides what a CAN FD protocol controller is allowed to do on the bus. It sits on an APB-style slave port and holds a control register with a run enable and a self-clearing soft reset, a mode register that picks one of sleep, loopback or snoop behaviour (or plain normal operation), and a read-only status word. From these it derives a one-hot operating mode for the controller core, a signal that forces the bus line to its recessive level, and a write permit used by the neighbouring transfer-layer configuration registers.

While the enable bit is clear the controller sits in configuration mode: the bus is held recessive, no frames move, and every mode and configuration field may be rewritten. Once the enable bit is set, the loopback and snoop selections are frozen. Only the sleep bit and a resume request bit may still change. Clearing the enable bit at run time drops the controller back to configuration mode at once and raises a one-cycle restart request. Both the power-on reset and the soft reset open a busy window during which the bus master must not start a new transaction.

Register layout (byte offsets): control at 0x0 (bit 0 soft reset, write-only; bit 1 enable), mode at 0x4 (bit 0 sleep, bit 1 loopback, bit 2 snoop, bit 3 resume request), status at 0x8 (bit 0 configuration flag, bit 1 busy). All other bits and offsets read as zero.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset the enable bit reads 0, the mode register reads 0, status bit 0 (configuration flag) reads 1 and `mode_oh` equals 5'b00001 (configuration).
- R2: Control register bit 0 (soft reset) always reads 0, and bits above bit 1 of the control register, above bit 3 of the mode register and above bit 1 of the status register read 0.
- R3: While the enable bit is 0, `mode_oh` is 5'b00001 and `force_recessive` is 1; while it is 1, `force_recessive` is 0.
- R4: With the enable bit set, `mode_oh` is 5'b01000 (loopback) if loopback is set, else 5'b10000 (snoop) if snoop is set, else 5'b00100 (sleep) if sleep is set, else 5'b00010 (normal).
- R5: Exactly one bit of `mode_oh` is 1 in every cycle after reset.
- R6: A write to the mode register while the enable bit is 1 leaves loopback (bit 1) and snoop (bit 2) unchanged but updates sleep (bit 0) and resume request (bit 3); while the enable bit is 0 all four bits are written.
- R7: `cfg_wr_permit` is 1 exactly when the enable bit is 0.
- R8: Writing 1 to control bit 0 clears the enable bit and the whole mode register regardless of the other written bits, and status bit 1 (`busy`) is then 1 for exactly BUSY_CYCLES (16) cycles after the write edge.
- R9: After the power-on reset is released, `busy` is 1 for exactly BUSY_CYCLES clock edges and then 0.
- R10: When the enable bit goes from 1 to 0 (by a plain write or a soft reset), `restart` is 1 for exactly the one cycle that follows that write edge.
- R11: Reads of offsets other than 0x0, 0x4 and 0x8 return 0, writes to them change no register, and every access completes with `pready` 1 and `pslverr` 0.
- R12: `resume_req` follows mode register bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (12) | Byte address |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data, valid while selected |
| pready | output | 1 | Always 1, single-cycle access |
| pslverr | output | 1 | Always 0 |
| mode_oh | output | 5 | One-hot mode: bit0 config, bit1 normal, bit2 sleep, bit3 loopback, bit4 snoop |
| force_recessive | output | 1 | Hold the bus line recessive |
| cfg_wr_permit | output | 1 | Transfer-layer configuration registers may be written |
| resume_req | output | 1 | Run-time resume request bit |
| restart | output | 1 | One-cycle request to restart the controller core |
| busy | output | 1 | Post-reset window, no new bus transaction allowed |

## Verification
Every cycle, the assertions check that the mode vector stays one-hot, that configuration mode and the recessive force coincide with the write permit, that loopback and snoop never move while enabled outside a soft reset, that a restart pulse only follows a falling enable, that the busy counter stays in range and that unmapped reads return zero. What the properties cannot show is the priority ordering across all mode-bit combinations, the exact length of the busy windows and the read-back values after protected writes; the bench sweeps every pair of old and new mode values through enable and disable sequences and counts the busy cycles after both resets.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

   // Register byte offsets
   localparam int unsigned OFS_CTRL = 32'h0;
   localparam int unsigned OFS_MODE = 32'h4;
   localparam int unsigned OFS_STAT = 32'h8;

   // Control register bits
   localparam int unsigned CTRL_SRST = 0;
   localparam int unsigned CTRL_EN   = 1;

   // Mode register bits
   localparam int unsigned MB_SLEEP  = 0;
   localparam int unsigned MB_LBACK  = 1;
   localparam int unsigned MB_SNOOP  = 2;
   localparam int unsigned MB_RESUME = 3;

   // One-hot mode vector
   localparam int unsigned MODE_W = 5;
   typedef enum logic [MODE_W-1:0] {
      MODE_CFG    = 5'b00001,
      MODE_NORMAL = 5'b00010,
      MODE_SLEEP  = 5'b00100,
      MODE_LBACK  = 5'b01000,
      MODE_SNOOP  = 5'b10000
   } mode_e;

endpackage

// File: rtl/cmc_busy_timer.sv
module cmc_busy_timer #(
   parameter int unsigned BUSY_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);

   generate
      if (BUSY_CYCLES < 1) begin : g_bad_len
         $error("cmc_busy_timer: BUSY_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= CNT_LOAD;
      else if (start)          cnt_q <= CNT_LOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

   AST_BUSY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LOAD);                                   // R8
   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);                                      // R8

endmodule

// File: rtl/cmc_mode_decode.sv
module cmc_mode_decode
   import can_mode_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              sel_sleep,
   input  logic              sel_lback,
   input  logic              sel_snoop,
   output logic [MODE_W-1:0] mode_oh
);
   mode_e mode;

   always_comb begin
      if (!enable)        mode = MODE_CFG;
      else if (sel_lback) mode = MODE_LBACK;
      else if (sel_snoop) mode = MODE_SNOOP;
      else if (sel_sleep) mode = MODE_SLEEP;
      else                mode = MODE_NORMAL;
   end

   assign mode_oh = mode;

   AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mode_oh) == 1);                            // R5
   AST_LBACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && sel_lback) |-> mode_oh[3]);                // R4

endmodule

// File: rtl/cmc_regfile.sv
module cmc_regfile
   import can_mode_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy,
   output logic [DATA_W-1:0] rdata,
   output logic              enable,
   output logic              sel_sleep,
   output logic              sel_lback,
   output logic              sel_snoop,
   output logic              resume,
   output logic              soft_rst,
   output logic              restart
);
   logic hit_ctrl, hit_mode, hit_stat;
   logic en_q, en_nxt, restart_q;
   logic sleep_q, lback_q, snoop_q, resume_q;

   assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
   assign hit_mode = (addr == ADDR_W'(OFS_MODE));
   assign hit_stat = (addr == ADDR_W'(OFS_STAT));

   assign soft_rst = wr_en && hit_ctrl && wdata[CTRL_SRST];

   always_comb begin
      en_nxt = en_q;
      if (soft_rst)                en_nxt = 1'b0;
      else if (wr_en && hit_ctrl)  en_nxt = wdata[CTRL_EN];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         restart_q <= 1'b0;
         sleep_q   <= 1'b0;
         lback_q   <= 1'b0;
         snoop_q   <= 1'b0;
         resume_q  <= 1'b0;
      end else begin
         en_q      <= en_nxt;
         restart_q <= en_q && !en_nxt;
         if (soft_rst) begin
            sleep_q  <= 1'b0;
            lback_q  <= 1'b0;
            snoop_q  <= 1'b0;
            resume_q <= 1'b0;
         end else if (wr_en && hit_mode) begin
            sleep_q  <= wdata[MB_SLEEP];
            resume_q <= wdata[MB_RESUME];
            if (!en_q) begin
               lback_q <= wdata[MB_LBACK];
               snoop_q <= wdata[MB_SNOOP];
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_ctrl) begin
         rdata[CTRL_EN] = en_q;
      end else if (hit_mode) begin
         rdata[MB_SLEEP]  = sleep_q;
         rdata[MB_LBACK]  = lback_q;
         rdata[MB_SNOOP]  = snoop_q;
         rdata[MB_RESUME] = resume_q;
      end else if (hit_stat) begin
         rdata[0] = !en_q;
         rdata[1] = busy;
      end
   end

   assign enable    = en_q;
   assign sel_sleep = sleep_q;
   assign sel_lback = lback_q;
   assign sel_snoop = snoop_q;
   assign resume    = resume_q;
   assign restart   = restart_q;

   AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !soft_rst) |=> ($stable(lback_q) && $stable(snoop_q)));   // R6
   AST_RESTART_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      restart_q |-> (!en_q && $past(en_q)));                             // R10
   AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!en_q && !lback_q && !snoop_q && !sleep_q));         // R8

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
   import can_mode_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned BUSY_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   output logic [MODE_W-1:0] mode_oh,
   output logic              force_recessive,
   output logic              cfg_wr_permit,
   output logic              resume_req,
   output logic              restart,
   output logic              busy
);
   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("can_mode_ctrl: ADDR_W must be at least 4");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("can_mode_ctrl: DATA_W must be at least 8");
      end
   endgenerate

   logic              wr_en, enable, soft_rst;
   logic              sel_sleep, sel_lback, sel_snoop;
   logic [DATA_W-1:0] reg_rdata;

   assign wr_en   = psel && penable && pwrite;
   assign pready  = 1'b1;
   assign pslverr = 1'b0;
   assign prdata  = psel ? reg_rdata : '0;

   cmc_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(paddr), .wdata(pwdata),
      .busy(busy), .rdata(reg_rdata), .enable(enable),
      .sel_sleep(sel_sleep), .sel_lback(sel_lback), .sel_snoop(sel_snoop),
      .resume(resume_req), .soft_rst(soft_rst), .restart(restart)
   );

   cmc_mode_decode i_decode (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .sel_sleep(sel_sleep), .sel_lback(sel_lback), .sel_snoop(sel_snoop),
      .mode_oh(mode_oh)
   );

   cmc_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) i_busy (
      .clk(clk), .rst_n(rst_n), .start(soft_rst), .busy(busy)
   );

   assign force_recessive = !enable;
   assign cfg_wr_permit   = !enable;

   AST_RECESSIVE_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      force_recessive == mode_oh[0]);                        // R3
   AST_PERMIT_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_permit == (mode_oh == MODE_CFG));               // R7
   AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && paddr != ADDR_W'(OFS_CTRL) && paddr != ADDR_W'(OFS_MODE)
            && paddr != ADDR_W'(OFS_STAT)) |-> (prdata == '0)); // R11

endmodule

// File: tb/test_can_mode_ctrl.sv
module test_can_mode_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr;
   logic [4:0]  mode_oh;
   logic        force_recessive, cfg_wr_permit, resume_req, restart, busy;

   int nchk = 0;
   int nerr = 0;

   always #5 clk = ~clk;

   can_mode_ctrl i_can_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
      .pslverr(pslverr), .mode_oh(mode_oh), .force_recessive(force_recessive),
      .cfg_wr_permit(cfg_wr_permit), .resume_req(resume_req),
      .restart(restart), .busy(busy)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] exp_mode(input logic en, input logic [3:0] m);
      if (!en)       return 5'b00001;
      else if (m[1]) return 5'b01000;
      else if (m[2]) return 5'b10000;
      else if (m[0]) return 5'b00100;
      else           return 5'b00010;
   endfunction

   task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
      @(negedge clk); penable = 1;
      @(negedge clk); psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
      @(negedge clk); penable = 1; #1;
      d = prdata;
      nchk++;
      if (pready !== 1'b1 || pslverr !== 1'b0) begin
         nerr++;
         $display("FAIL R11: actual ready/err %b%b expected 10", pready, pslverr);
      end
      @(negedge clk); psel = 0; penable = 0;
   endtask

   task automatic busy_window(input string req);
      for (int k = 1; k <= 16; k++) begin
         @(posedge clk); @(negedge clk);
         chk(req, {31'b0, busy}, {31'b0, (k < 16)});
      end
   endtask

   initial begin
      #1000000;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 mode_oh", {27'b0, mode_oh}, 32'h1);
      rst_n = 1;
      chk("R9 busy at release", {31'b0, busy}, 32'h1);
      busy_window("R9");

      apb_rd(12'h0, rd); chk("R1 ctrl", rd, 32'h0);
      apb_rd(12'h4, rd); chk("R1 mode", rd, 32'h0);
      apb_rd(12'h8, rd); chk("R1 status", rd, 32'h1);
      chk("R3 recessive", {31'b0, force_recessive}, 32'h1);
      chk("R7 permit", {31'b0, cfg_wr_permit}, 32'h1);

      // R2 reserved and write-only bits read 0
      apb_wr(12'h4, 32'hFFFF_FFF0);
      apb_rd(12'h4, rd); chk("R2 mode upper", rd, 32'h0);
      apb_wr(12'h0, 32'hFFFF_FFFE);
      apb_rd(12'h0, rd); chk("R2 ctrl upper", rd, 32'h2);
      apb_wr(12'h0, 32'h0);
      apb_rd(12'h8, rd); chk("R2 status", rd, 32'h1);

      // R4 R6 R10 R12 sweep: old mode m1 set in config, new mode m2 written while enabled
      for (int m1 = 0; m1 < 16; m1++) begin
         for (int m2 = 0; m2 < 16; m2++) begin
            logic [3:0] a = 4'(m1);
            logic [3:0] b = 4'(m2);
            logic [3:0] e = {b[3], a[2], a[1], b[0]};
            apb_wr(12'h4, {28'b0, a});
            apb_wr(12'h0, 32'h2);
            chk("R4 mode before", {27'b0, mode_oh}, {27'b0, exp_mode(1'b1, a)});
            chk("R3 not recessive", {31'b0, force_recessive}, 32'h0);
            apb_wr(12'h4, {28'b0, b});
            apb_rd(12'h4, rd); chk("R6 protected", rd, {28'b0, e});
            chk("R4 mode after", {27'b0, mode_oh}, {27'b0, exp_mode(1'b1, e)});
            chk("R12 resume", {31'b0, resume_req}, {31'b0, e[3]});
            chk("R7 permit off", {31'b0, cfg_wr_permit}, 32'h0);
            apb_wr(12'h0, 32'h0);
            chk("R10 pulse", {31'b0, restart}, 32'h1);
            chk("R3 cfg again", {27'b0, mode_oh}, 32'h1);
            @(posedge clk); @(negedge clk);
            chk("R10 single", {31'b0, restart}, 32'h0);
         end
      end

      // R6 config-time write of all bits
      apb_wr(12'h4, 32'h6);
      apb_rd(12'h4, rd); chk("R6 config write", rd, 32'h6);

      // R11 unmapped offsets
      apb_wr(12'hC, 32'hFFFF_FFFF);
      apb_wr(12'h2, 32'hFFFF_FFFF);
      apb_rd(12'hC, rd); chk("R11 read C", rd, 32'h0);
      apb_rd(12'h100, rd); chk("R11 read 100", rd, 32'h0);
      apb_rd(12'h0, rd); chk("R11 ctrl kept", rd, 32'h0);
      apb_rd(12'h4, rd); chk("R11 mode kept", rd, 32'h6);

      // R8 soft reset while enabled with other bits set
      apb_wr(12'h4, 32'hF);
      apb_wr(12'h0, 32'h2);
      chk("R4 lback prio", {27'b0, mode_oh}, 32'h8);
      apb_wr(12'h0, 32'h3);
      chk("R8 busy start", {31'b0, busy}, 32'h1);
      chk("R10 on soft reset", {31'b0, restart}, 32'h1);
      busy_window("R8");
      apb_rd(12'h0, rd); chk("R8 ctrl cleared", rd, 32'h0);
      apb_rd(12'h4, rd); chk("R8 mode cleared", rd, 32'h0);
      apb_rd(12'h8, rd); chk("R8 status", rd, 32'h1);

      // R8 soft reset in config mode: no restart pulse
      apb_wr(12'h0, 32'h1);
      chk("R10 none from config", {31'b0, restart}, 32'h0);
      apb_rd(12'h8, rd); chk("R8 busy in status", rd, 32'h3);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule